// File: doc/BRIEF.md
# Polyphase I/Q Splitter

This block takes a real 8-bit two's-complement IF sample stream, with one sample on every clock, and produces its in-phase and quadrature parts. An internal selector toggles on every clock. Its phase is fixed by the first rising edge after reset is released. It sends the samples on alternate clocks to two first-order all-pass branches. The branches use different coefficients, so their outputs approximate a 90 degree phase split across the useful band. One real sample and the imaginary sample that follows it form a pair.

Each branch result is rounded and saturated to 8 bits. The results leave on a single 8-bit bus as I followed by Q, and a strobe shows which half is on the bus. A mode input decides how a pair is presented:
- With the mode input low, I and Q are the raw branch outputs. This is the baseband presentation.
- With the mode input high, each pair is rotated by a further quarter turn per pair. This moves the output to the intermediate-frequency presentation.

After reset, the bus is held at zero until the filters have seen a few pairs.

Top module: `iqSplitTop`

## Requirements
- R1: While reset (active high) is asserted, and for the first two clock edges after it is released, `iqOut` is 0 and `iqIsI` is 0.
- R2: The sample taken on the first rising edge after reset release goes to the real branch. Later samples alternate real, imaginary, real, and so on. With a constant real-path value A and imaginary-path value B in baseband mode, the bus settles to I = A and Q = B.
- R3: On each of its load edges, a branch computes d = x - yPrev and y = xPrev + (d >>> sa) + (d >>> sb). Here x is the input sample times 16, held in 16 bits. The real branch uses sa=3, sb=4 (coefficient 3/16). The imaginary branch uses sa=1, sb=3 (coefficient 5/8). Reset clears xPrev and yPrev.
- R4: Number the pairs k from 0, with pair k taking its real sample on edge 2k+1 after release. I of pair k is on the bus after edge 2k+3 with `iqIsI` = 1. Q of pair k is on the bus after edge 2k+4 with `iqIsI` = 0.
- R5: Each output value v (16 times the 8-bit scale) becomes (v + 8) >>> 4 and is then clamped to -128..127. There is no wrap-around, so -(-128) gives 127.
- R6: With `ifMode` = 0, I is the real-branch output and Q is the imaginary-branch output.
- R7: With `ifMode` = 1, pair k uses rotation phase p = k mod 4, and reset clears the phase count. The mapping (I,Q) is: p=0 gives (re,im); p=1 gives (im,-re); p=2 gives (-re,-im); p=3 gives (-im,re). The phase advances once per pair in either mode.
- R8: The outputs of pairs 0 and 1 (FILL_PAIRS = 2) are forced to 0 for both I and Q. The strobe still runs for these pairs.
- R9: `ifMode` is sampled on the edge that puts I on the bus. The Q of the same pair uses that same setting, even if `ifMode` changes before the Q edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one input sample per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ifMode | input | 1 | 0: baseband presentation, 1: quarter-turn rotation per pair |
| sampleIn | input | 8 | Real IF input sample, two's complement |
| iqOut | output | 8 | Time-multiplexed I/Q output, two's complement |
| iqIsI | output | 1 | High while I is on `iqOut`, low while Q is on it |

## Verification
The bench uses several input patterns, each aimed at a different fault.
- A sweep of every 8-bit value, each held for one pair, exposes sign-extension, shift and rounding errors in the branch arithmetic.
- Separate constant values on the real and imaginary paths settle to known I and Q levels. A swapped selector phase shows up as swapped outputs.
- A three-quarter-rate tone shows the phase relationship between the branches.
- A -128 level under rotation forces the negate-and-saturate corner.
- A pseudo-random stream, with the mode flipped between the I and Q edges of a pair, tells apart mode capture per pair from capture per clock.
- A reset in the middle of the stream checks that the selector phase, the rotation phase and the fill counter all restart.

// File: rtl/iqSplitPkg.sv
package iqSplitPkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic       loadReal;
    logic       loadImag;
    logic       emitI;
    logic       emitQ;
    logic       zeroOut;
    logic [1:0] mixPh;
  } iqCtrl_t;

endpackage

// File: rtl/iqAllpass.sv
module iqAllpass #(
  parameter int W    = 16,
  parameter int SH_A = 3,
  parameter int SH_B = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] xIn,
  output logic signed [W-1:0] yOut
);

  logic signed [W-1:0] xPrev;
  logic signed [W-1:0] diff;
  logic signed [W-1:0] yNext;

  // first-order all-pass, coefficient as a sum of two power-of-two terms
  always_comb begin
    diff  = xIn - yOut;
    yNext = xPrev + (diff >>> SH_A) + (diff >>> SH_B);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xPrev <= '0;
      yOut  <= '0;
    end else if (en) begin
      xPrev <= xIn;
      yOut  <= yNext;
    end
  end

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(yOut));

endmodule

// File: rtl/iqSplitCtrl.sv
module iqSplitCtrl
  import iqSplitPkg::*;
#(
  parameter int FILL_PAIRS = 2
) (
  input  logic    clk,
  input  logic    rst,
  output iqCtrl_t ctl,
  output logic    strobe
);

  localparam int CW = $clog2(FILL_PAIRS + 2);
  localparam logic [CW-1:0] CNT_TOP  = CW'(FILL_PAIRS + 1);
  localparam logic [CW-1:0] CNT_FILL = CW'(FILL_PAIRS);

  logic          sel;      // 0: real sample this edge, 1: imaginary
  logic [CW-1:0] pairCnt;  // completed pairs, saturating
  logic [1:0]    mixPh;
  logic          emitI;
  logic          emitQ;

  always_comb begin
    emitI        = !sel && (pairCnt != '0);
    emitQ        = sel && strobe;
    ctl.loadReal = !sel;
    ctl.loadImag = sel;
    ctl.emitI    = emitI;
    ctl.emitQ    = emitQ;
    ctl.zeroOut  = (pairCnt <= CNT_FILL);
    ctl.mixPh    = mixPh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel     <= 1'b0;
      pairCnt <= '0;
      mixPh   <= 2'd0;
      strobe  <= 1'b0;
    end else begin
      sel    <= !sel;
      strobe <= emitI;
      if (sel && (pairCnt != CNT_TOP)) pairCnt <= pairCnt + CW'(1);
      if (emitQ) mixPh <= mixPh + 2'd1;
    end
  end

  // R2
  sel_alt_hi_chk: assert property (@(posedge clk) disable iff (rst)
    sel |=> !sel);
  // R2
  sel_alt_lo_chk: assert property (@(posedge clk) disable iff (rst)
    !sel |=> sel);
  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);
  // R7
  mix_step_chk: assert property (@(posedge clk) disable iff (rst)
    !(sel && strobe) |=> $stable(mixPh));

endmodule

// File: rtl/iqSplitPath.sv
module iqSplitPath
  import iqSplitPkg::*;
#(
  parameter int IN_W  = 8,
  parameter int FRAC  = 4,
  parameter int W     = 16,
  parameter int RE_SA = 3,
  parameter int RE_SB = 4,
  parameter int IM_SA = 1,
  parameter int IM_SB = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  iqCtrl_t         ctl,
  input  logic            mode,
  input  logic [IN_W-1:0] dataIn,
  output logic [IN_W-1:0] dataOut
);

  localparam int PAD = W - IN_W - FRAC;
  localparam logic signed [W+1:0] HALF = (W+2)'(1) <<< (FRAC - 1);
  localparam logic signed [W+1:0] OMAX = (W+2)'((1 << (IN_W - 1)) - 1);
  localparam logic signed [W+1:0] OMIN = (W+2)'(-(1 << (IN_W - 1)));

  logic signed [W-1:0]  xExt;
  logic signed [W-1:0]  yBr [2];
  logic [1:0]           brEn;
  logic signed [W:0]    reW, imW, rotI, rotQ;
  logic signed [IN_W-1:0] satI, satQ, qHold;

  assign xExt = {{PAD{dataIn[IN_W-1]}}, dataIn, {FRAC{1'b0}}};
  assign brEn = {ctl.loadImag, ctl.loadReal};

  for (genvar b = 0; b < 2; b++) begin : gBranch
    localparam int SA = (b == 0) ? RE_SA : IM_SA;
    localparam int SB = (b == 0) ? RE_SB : IM_SB;
    iqAllpass #(.W(W), .SH_A(SA), .SH_B(SB)) ap_i (
      .clk (clk),
      .rst (rst),
      .en  (brEn[b]),
      .xIn (xExt),
      .yOut(yBr[b])
    );
  end

  function automatic logic signed [IN_W-1:0] roundSat(input logic signed [W:0] v);
    logic signed [W+1:0] t;
    t = ($signed({v[W], v}) + HALF) >>> FRAC;
    if (t > OMAX)      t = OMAX;
    else if (t < OMIN) t = OMIN;
    return t[IN_W-1:0];
  endfunction

  always_comb begin
    reW = {yBr[0][W-1], yBr[0]};
    imW = {yBr[1][W-1], yBr[1]};
    rotI = reW;
    rotQ = imW;
    if (mode) begin
      case (ctl.mixPh)
        2'd1:    begin rotI = imW;  rotQ = -reW; end
        2'd2:    begin rotI = -reW; rotQ = -imW; end
        2'd3:    begin rotI = -imW; rotQ = reW;  end
        default: begin rotI = reW;  rotQ = imW;  end
      endcase
    end
    satI = roundSat(rotI);
    satQ = roundSat(rotQ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut <= '0;
      qHold   <= '0;
    end else if (ctl.emitI) begin
      dataOut <= ctl.zeroOut ? '0 : satI;
      qHold   <= ctl.zeroOut ? '0 : satQ;
    end else if (ctl.emitQ) begin
      dataOut <= qHold;
    end else begin
      dataOut <= '0;
    end
  end

  // R8
  fill_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.emitI && ctl.zeroOut) |=> (dataOut == '0));
  // R9
  q_from_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.emitQ |=> (dataOut == $past(qHold)));

endmodule

// File: rtl/iqSplitTop.sv
module iqSplitTop
  import iqSplitPkg::*;
#(
  parameter int IN_W       = 8,
  parameter int FRAC       = 4,
  parameter int ACC_W      = 16,
  parameter int FILL_PAIRS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ifMode,
  input  logic [IN_W-1:0] sampleIn,
  output logic [IN_W-1:0] iqOut,
  output logic            iqIsI
);

  iqCtrl_t ctl;

  iqSplitCtrl #(.FILL_PAIRS(FILL_PAIRS)) ctrl_i (
    .clk   (clk),
    .rst   (rst),
    .ctl   (ctl),
    .strobe(iqIsI)
  );

  iqSplitPath #(.IN_W(IN_W), .FRAC(FRAC), .W(ACC_W)) path_i (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .mode   (ifMode),
    .dataIn (sampleIn),
    .dataOut(iqOut)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> ((iqOut == '0) && !iqIsI));

endmodule

// File: tb/iqSplitTop_tb_top.sv
module iqSplitTop_tb_top;

  localparam int FILL = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ifMode = 1'b0;
  logic [7:0] sampleIn = 8'd0;
  wire  [7:0] iqOut;
  wire        iqIsI;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  int eIdx, pairM, strbM, mixM, qHoldM, qModeM, expOut, expStb;
  int xP [2];
  int yP [2];
  string tag, qTagM;
  logic [15:0] lfsr = 16'hACE1;

  iqSplitTop dut_i (
    .clk(clk), .rst(rst), .ifMode(ifMode),
    .sampleIn(sampleIn), .iqOut(iqOut), .iqIsI(iqIsI)
  );

  always #4 clk = ~clk;

  task automatic check(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  function automatic int rs(input int v, output bit sat);
    int t;
    t = (v + 8) >>> 4;
    sat = 1'b0;
    if (t > 127) begin t = 127; sat = 1'b1; end
    else if (t < -128) begin t = -128; sat = 1'b1; end
    return t;
  endfunction

  task automatic modelReset();
    eIdx = 0; pairM = 0; strbM = 0; mixM = 0; qHoldM = 0; qModeM = 0;
    xP[0] = 0; xP[1] = 0; yP[0] = 0; yP[1] = 0;
    qTagM = "R1";
  endtask

  // one clock edge of the behaviour set out in R2..R9
  task automatic modelEdge(input int v, input bit m);
    int sel, ri, rq, vi, vq, x, d;
    bit s1, s2, zero;
    sel = eIdx % 2;
    if (sel == 0 && pairM >= 1) begin
      ri = yP[0]; rq = yP[1];
      if (m) begin
        case (mixM)
          1: begin ri = yP[1];  rq = -yP[0]; end
          2: begin ri = -yP[0]; rq = -yP[1]; end
          3: begin ri = -yP[1]; rq = yP[0];  end
          default: ;
        endcase
      end
      vi = rs(ri, s1);
      vq = rs(rq, s2);
      zero = (pairM <= FILL);
      expOut = zero ? 0 : vi;
      qHoldM = zero ? 0 : vq;
      qModeM = m;
      expStb = 1;
      tag   = zero ? "R8" : (s1 ? "R5" : (m ? "R7" : "R3 R6"));
      qTagM = zero ? "R8" : (s2 ? "R5" : (m ? "R7" : "R3 R6"));
    end else if (sel == 1 && strbM == 1) begin
      expOut = qHoldM;
      expStb = 0;
      mixM = (mixM + 1) % 4;
      tag = (m != qModeM) ? "R9" : qTagM;
    end else begin
      expOut = 0;
      expStb = 0;
      tag = "R1";
    end
    strbM = expStb;
    x = v * 16;
    d = x - yP[sel];
    yP[sel] = xP[sel] + (d >>> (sel == 0 ? 3 : 1)) + (d >>> (sel == 0 ? 4 : 3));
    xP[sel] = x;
    if (sel == 1 && pairM < FILL + 1) pairM++;
    eIdx++;
  endtask

  task automatic cycle(input int v, input bit m);
    sampleIn = v[7:0];
    ifMode = m;
    @(posedge clk);
    modelEdge(v, m);
    @(negedge clk);
    check(tag, int'($signed(iqOut)), expOut);
    check((tag == "R1") ? "R1 strobe" : "R4 strobe", int'(iqIsI), expStb);
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R1 reset data", int'(iqOut), 0);
      check("R1 reset strobe", int'(iqIsI), 0);
    end
    rst = 1'b0;
    modelReset();
  endtask

  task automatic dcCheck(input int a, input int b);
    for (int i = 0; i < 60; i++) begin cycle(a, 0); cycle(b, 0); end
    cycle(a, 0);
    check("R2 settled I", int'($signed(iqOut)), a);
    check("R2 strobe on I", int'(iqIsI), 1);
    cycle(b, 0);
    check("R2 settled Q", int'($signed(iqOut)), b);
  endtask

  initial begin
    int tone [4] = '{100, -100, -100, 100};
    bit mm;
    modelReset();
    @(negedge clk);
    doReset();
    // exhaustive level sweep, one pair per value
    for (int v = -128; v < 128; v++) begin cycle(v, 0); cycle(v, 0); end
    dcCheck(100, -50);
    // three-quarter-rate tone, both presentations
    for (int i = 0; i < 200; i++) cycle(tone[i % 4], 0);
    for (int i = 0; i < 200; i++) cycle(tone[i % 4], 1);
    // negate corner: -128 rotated gives +128, clamped (R5)
    for (int i = 0; i < 80; i++) cycle(-128, 1);
    for (int i = 0; i < 100; i++) cycle((i % 4 < 2) ? 127 : -128, i >= 50);
    // pseudo-random stream, mode flipping inside pairs (R9)
    mm = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i % 5 == 0) mm = ~mm;
      cycle(int'($signed(lfsr[7:0])), mm);
    end
    // odd edge count, then mid-stream reset
    cycle(5, 1);
    doReset();
    for (int i = 0; i < 100; i++) cycle(tone[i % 4], 1);
    dcCheck(-70, 33);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule